// File: doc/BRIEF.md
# Timer-Latch Fault Protection Controller

This block supervises a two-rail supply and decides when the rails must be forced off. It watches an undervoltage flag on rail A's feedback (feedback under 75% of target), an over-temperature flag, an overcurrent flag on rail B and two supply comparator flags. From these it drives three registered outputs: a global latched-off signal, a supply lockout signal and a shutdown signal for rail B alone.

A rail A short or an over-temperature condition must persist for a programmable dwell time before it latches every output off. The dwell time is nominally 10 ms and is given in clock cycles. Short detection is blanked while rail A itself is soft-starting, but it is not blanked while only rail B is soft-starting. Once set, the latch is cleared only by taking both enables low or by letting the supply fall to the stop level. Supply lockout has hysteresis and releases by itself. A rail B overcurrent shuts only rail B, and rail B returns as soon as the overcurrent clears. While the low-power-mode pin is high, every protection function is inert.

Top module: `prot_latch_ctrl`

## Requirements
- R1: After reset `lockout_o`=1, `latch_off_o`=0 and `rail_b_off_o`=0. One clock edge that samples `vdd_stop_i`=1 (supply at or below the stop level) outside low-power mode sets `lockout_o`=1.
- R2: One edge that samples `vdd_start_i`=1 (supply at or above the start level) with `vdd_stop_i`=0 clears `lockout_o`. With both flags at 0 (the band between the thresholds), `lockout_o` holds its value.
- R3: The enable pins cannot clear `lockout_o`. While `lockout_o`=1, no fault flag can set `latch_off_o` or `rail_b_off_o`.
- R4: With at least one enable high, `short_a_i`=1 sampled high on TRIP_CYC consecutive edges sets `latch_off_o` after the last of those edges. If the flag drops for a single edge, the count restarts from zero.
- R5: `short_a_i` is ignored while `ss_a_act_i`=1. `ss_b_act_i`=1 does not mask it.
- R6: `ot_i`=1 held for TRIP_CYC consecutive edges sets `latch_off_o` in the same way.
- R7: `latch_off_o` holds while either enable is high and `vdd_stop_i`=0. It clears on the edge that samples both enables low or `vdd_stop_i`=1. Clearing has priority over setting.
- R8: `oc_b_i`=1 sets `rail_b_off_o` one edge later and never sets `latch_off_o`. `rail_b_off_o` clears one edge after `oc_b_i` returns to 0.
- R9: While `lp_mode_i`=1, no flag can set `latch_off_o` or `rail_b_off_o`, and `lockout_o` is driven to 0 even when `vdd_stop_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_a_i | input | 1 | Rail A enable pin |
| en_b_i | input | 1 | Rail B enable pin |
| lp_mode_i | input | 1 | Low-power mode; disables all protection |
| vdd_stop_i | input | 1 | 1 = supply at or below the lockout stop level |
| vdd_start_i | input | 1 | 1 = supply at or above the lockout start level |
| ss_a_act_i | input | 1 | Rail A soft-start in progress |
| ss_b_act_i | input | 1 | Rail B soft-start in progress |
| short_a_i | input | 1 | Rail A feedback below 75% of target |
| ot_i | input | 1 | Over-temperature detected |
| oc_b_i | input | 1 | Rail B overcurrent detected |
| latch_off_o | output | 1 | All outputs latched off |
| lockout_o | output | 1 | Supply lockout active |
| rail_b_off_o | output | 1 | Rail B shut by overcurrent |

## Verification
The bench builds the block with TRIP_CYC set to 16 in place of the 10000-cycle default. At that value the exact trip edge, the restart of the dwell count after a one-edge dropout, and a soft-start blanking window longer than the dwell can all be checked in a few hundred cycles. Lockout hysteresis is exercised by holding the supply in the band between the two thresholds.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum int unsigned {
    SRC_SHORT = 0,
    SRC_THERM = 1
  } fault_src_e;
  localparam int unsigned NSRC = 2;
endpackage

// File: rtl/fault_dwell_timer.sv
module fault_dwell_timer #(
  parameter int unsigned TRIP_CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic flag_i,
  output logic expire_o
);
  localparam int unsigned CW = (TRIP_CYC < 2) ? 1 : $clog2(TRIP_CYC);
  localparam logic [CW-1:0] LAST = CW'(TRIP_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          live;

  assign live     = arm_i & flag_i;
  assign expire_o = live & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!live)         cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/supply_lockout.sv
module supply_lockout (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_mode_i,
  input  logic vdd_stop_i,
  input  logic vdd_start_i,
  output logic lockout_o
);
  logic lock_q;

  // hysteresis: stop wins, start releases, band holds
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          lock_q <= 1'b1;
    else if (lp_mode_i)   lock_q <= 1'b0;
    else if (vdd_stop_i)  lock_q <= 1'b1;
    else if (vdd_start_i) lock_q <= 1'b0;
  end

  assign lockout_o = lock_q;
endmodule

// File: rtl/rail_b_guard.sv
module rail_b_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic oc_i,
  output logic off_o
);
  logic off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= 1'b0;
    else         off_q <= arm_i & oc_i;
  end

  assign off_o = off_q;
endmodule

// File: rtl/prot_latch_ctrl.sv
module prot_latch_ctrl
  import prot_pkg::*;
#(
  parameter int unsigned TRIP_CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_a_i,
  input  logic en_b_i,
  input  logic lp_mode_i,
  input  logic vdd_stop_i,
  input  logic vdd_start_i,
  input  logic ss_a_act_i,
  input  logic ss_b_act_i,
  input  logic short_a_i,
  input  logic ot_i,
  input  logic oc_b_i,
  output logic latch_off_o,
  output logic lockout_o,
  output logic rail_b_off_o
);
  logic            lock_w;
  logic            latch_q;
  logic            any_en;
  logic            clr;
  logic            arm;
  logic [NSRC-1:0] flag;
  logic [NSRC-1:0] expire;
  logic            ss_b_unused;

  assign ss_b_unused = ss_b_act_i; // rail B soft-start never blanks rail A detection

  assign any_en = en_a_i | en_b_i;
  assign clr    = ~any_en | vdd_stop_i;
  assign arm    = ~lp_mode_i & ~lock_w & any_en & ~latch_q;

  assign flag[SRC_SHORT] = short_a_i & ~ss_a_act_i;
  assign flag[SRC_THERM] = ot_i;

  supply_lockout u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lp_mode_i  (lp_mode_i),
    .vdd_stop_i (vdd_stop_i),
    .vdd_start_i(vdd_start_i),
    .lockout_o  (lock_w)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_tmr
    fault_dwell_timer #(.TRIP_CYC(TRIP_CYC)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .arm_i   (arm),
      .flag_i  (flag[g]),
      .expire_o(expire[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      latch_q <= 1'b0;
    else if (clr)     latch_q <= 1'b0;
    else if (|expire) latch_q <= 1'b1;
  end

  rail_b_guard u_rb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (arm),
    .oc_i  (oc_b_i),
    .off_o (rail_b_off_o)
  );

  assign latch_off_o = latch_q;
  assign lockout_o   = lock_w;
endmodule

// File: rtl/prot_latch_ctrl_chk.sv
module prot_latch_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_a_i,
  input logic en_b_i,
  input logic lp_mode_i,
  input logic vdd_stop_i,
  input logic vdd_start_i,
  input logic oc_b_i,
  input logic latch_off_o,
  input logic lockout_o,
  input logic rail_b_off_o
);
  a_r1_stop_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vdd_stop_i && !lp_mode_i |=> lockout_o);

  a_r2_start_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vdd_stop_i && vdd_start_i |=> !lockout_o);

  a_r2_band_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o && !vdd_stop_i && !vdd_start_i && !lp_mode_i |=> lockout_o);

  a_r3_lock_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o && !latch_off_o |=> !latch_off_o && !rail_b_off_o);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_a_i && !en_b_i) || vdd_stop_i |=> !latch_off_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_off_o && (en_a_i || en_b_i) && !vdd_stop_i |=> latch_off_o);

  a_r8_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oc_b_i |=> !rail_b_off_o);

  a_r8_shut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_b_i && !lp_mode_i && (en_a_i || en_b_i) && !lockout_o && !latch_off_o
    |=> rail_b_off_o);

  a_r9_lp_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_mode_i |=> !$rose(latch_off_o) && !rail_b_off_o && !lockout_o);
endmodule

bind prot_latch_ctrl prot_latch_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_a_i      (en_a_i),
  .en_b_i      (en_b_i),
  .lp_mode_i   (lp_mode_i),
  .vdd_stop_i  (vdd_stop_i),
  .vdd_start_i (vdd_start_i),
  .oc_b_i      (oc_b_i),
  .latch_off_o (latch_off_o),
  .lockout_o   (lockout_o),
  .rail_b_off_o(rail_b_off_o)
);

// File: tb/sim_prot_latch_ctrl.sv
module sim_prot_latch_ctrl;
  localparam int unsigned TRIP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_a = 0, en_b = 0, lp = 0, vstop = 1, vstart = 0;
  logic ss_a = 0, ss_b = 0, sh_a = 0, ot = 0, oc_b = 0;
  logic latch_off, lockout, rb_off;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  prot_latch_ctrl #(.TRIP_CYC(TRIP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_a_i(en_a), .en_b_i(en_b),
    .lp_mode_i(lp), .vdd_stop_i(vstop), .vdd_start_i(vstart),
    .ss_a_act_i(ss_a), .ss_b_act_i(ss_b), .short_a_i(sh_a), .ot_i(ot),
    .oc_b_i(oc_b), .latch_off_o(latch_off), .lockout_o(lockout),
    .rail_b_off_o(rb_off)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic power_good();
    vstop = 0; vstart = 1; step(1);
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 reset lockout", lockout, 1'b1);
    chk("R1 reset latch", latch_off, 1'b0);
    chk("R1 reset rail_b", rb_off, 1'b0);
    rst_n = 1; step(1);
  endtask

  task automatic t_lockout();
    power_good();
    chk("R2 release", lockout, 1'b0);
    vstart = 0; step(3);
    chk("R2 band hold low", lockout, 1'b0);
    vstop = 1; step(1);
    chk("R1 stop locks", lockout, 1'b1);
    vstop = 0; step(3);
    chk("R2 band hold high", lockout, 1'b1);
    power_good();
    chk("R2 release again", lockout, 1'b0);
  endtask

  task automatic t_lock_enables();
    vstop = 1; vstart = 0; step(1);
    en_a = 1; en_b = 1; step(2);
    chk("R3 enables do not release", lockout, 1'b1);
    sh_a = 1; oc_b = 1; step(TRIP + 2);
    chk("R3 no latch in lockout", latch_off, 1'b0);
    chk("R3 no rail_b shut in lockout", rb_off, 1'b0);
    sh_a = 0; oc_b = 0; en_a = 0; en_b = 0;
    power_good();
  endtask

  task automatic t_short_trip();
    en_a = 1; sh_a = 1; step(TRIP - 1);
    chk("R4 no trip before window", latch_off, 1'b0);
    sh_a = 0; step(1);
    sh_a = 1; step(TRIP - 1);
    chk("R4 count restarted", latch_off, 1'b0);
    step(1);
    chk("R4 trip at window", latch_off, 1'b1);
    sh_a = 0;
    en_b = 1; en_a = 0; step(2);
    chk("R7 hold with one enable", latch_off, 1'b1);
    en_b = 0; step(1);
    chk("R7 clear on both enables low", latch_off, 1'b0);
  endtask

  task automatic t_soft_start();
    en_a = 1; ss_a = 1; sh_a = 1; step(TRIP + 4);
    chk("R5 masked during rail A soft-start", latch_off, 1'b0);
    ss_a = 0; ss_b = 1; step(TRIP);
    chk("R5 rail B soft-start does not mask", latch_off, 1'b1);
    sh_a = 0; ss_b = 0; en_a = 0; step(1);
    chk("R7 clear", latch_off, 1'b0);
  endtask

  task automatic t_thermal();
    en_a = 1; en_b = 1; ot = 1; step(TRIP - 1);
    chk("R6 no trip early", latch_off, 1'b0);
    step(1);
    chk("R6 thermal trip", latch_off, 1'b1);
    ot = 0; step(2);
    chk("R7 holds after flag clears", latch_off, 1'b1);
    vstop = 1; step(1);
    chk("R7 clear on supply stop", latch_off, 1'b0);
    chk("R1 lockout on stop", lockout, 1'b1);
    power_good();
  endtask

  task automatic t_rail_b();
    en_a = 1; en_b = 1; oc_b = 1; step(1);
    chk("R8 rail B shut", rb_off, 1'b1);
    step(TRIP + 2);
    chk("R8 no global latch", latch_off, 1'b0);
    oc_b = 0; step(1);
    chk("R8 rail B recovers", rb_off, 1'b0);
  endtask

  task automatic t_low_power();
    lp = 1; sh_a = 1; ot = 1; oc_b = 1; step(TRIP + 4);
    chk("R9 no latch in lp", latch_off, 1'b0);
    chk("R9 no rail_b shut in lp", rb_off, 1'b0);
    vstop = 1; vstart = 0; step(1);
    chk("R9 no lockout in lp", lockout, 1'b0);
    sh_a = 0; ot = 0; oc_b = 0; lp = 0; step(1);
    chk("R1 lockout after lp exit", lockout, 1'b1);
    power_good();
    en_a = 0; en_b = 0;
  endtask

  initial begin
    t_reset();
    t_lockout();
    t_lock_enables();
    t_short_trip();
    t_soft_start();
    t_thermal();
    t_rail_b();
    t_low_power();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule